// File: doc/BRIEF.md
# Multi-issue reservation station scheduler

This block holds renamed instructions that are waiting to execute. Each cycle it can take up to three new instructions from the rename stage. Each of these carries an opcode, an execution class, its reorder tag and two source operands. A source operand arrives either as a ready value or as the tag of the instruction that will produce it. Result broadcasts from the execution units carry a tag and a value. A broadcast marks every waiting operand that names the same tag as ready and stores the value in it. An instruction whose operands are both ready becomes a candidate for the issue port that serves its class. Each port sends out at most one instruction per cycle, and up to five ports fire together. Instructions therefore leave the buffer out of program order. When a port has several candidates, the oldest one by reorder tag goes first.

The front end is stalled when the free entries cannot hold every instruction presented on the dispatch lanes. A flush removes every entry younger than a given reorder tag. An instruction may wait in the buffer for any number of cycles. Writing an instruction into the buffer takes one clock edge. Moving it out to a port takes one more clock edge.

Top module: `rs_sched`

## Requirements
- R1: After reset the buffer is empty, every `iss_valid` bit is 0, and `dsp_ready` is 1 when no flush is requested.
- R2: An instruction with both operands ready that is dispatched before clock edge k is written at edge k. It appears on its port after edge k+1, and not earlier. Its opcode, tag and operand values appear unchanged.
- R3: The class field selects the port: class value c is issued only on port c. Each port issues at most one instruction per cycle. Five instructions of different classes can issue in the same cycle.
- R4: Among ready entries of the same class, the oldest goes first. Tag a is older than tag b when (a - b) mod 128 is 64 or more. Under this rule tag 126 is older than tag 1.
- R5: A valid broadcast whose tag equals the tag of a not-ready held operand sets that operand ready and stores the broadcast value. The entry can issue one cycle later at the earliest, and the issued operand equals the broadcast value.
- R6: A broadcast in the same cycle as the dispatch of a matching not-ready operand is captured into the new entry. It is not lost.
- R7: An entry with an operand that is not ready stays in the buffer and never issues, however many cycles pass. It issues once the operand becomes ready.
- R8: `dsp_ready` is 0 when the free entries are fewer than the number of asserted `dsp_valid` lanes, or when a flush is requested. Nothing presented in such a cycle is accepted.
- R9: A flush removes the held entries whose tag is strictly younger than `flush_tag`. Entries that are older or have an equal tag stay. No instruction issues in the cycle after a flush.
- R10: The buffer holds 20 entries. Valid lanes are placed into free entries, and all three lanes can be written in one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dsp_valid | input | 3 | Per-lane dispatch request |
| dsp_ready | output | 1 | All presented lanes are accepted this cycle |
| dsp_op | input | 3x6 | Opcode per lane |
| dsp_cls | input | 3x3 | Execution class per lane (equals the target port index) |
| dsp_tag | input | 3x7 | Reorder tag per lane |
| dsp_s1_rdy | input | 3 | Source 1 already holds its value |
| dsp_s1_tag | input | 3x7 | Producer tag of source 1 |
| dsp_s1_val | input | 3x16 | Value of source 1 |
| dsp_s2_rdy | input | 3 | Source 2 already holds its value |
| dsp_s2_tag | input | 3x7 | Producer tag of source 2 |
| dsp_s2_val | input | 3x16 | Value of source 2 |
| bc_valid | input | 2 | Result broadcast valid per bus |
| bc_tag | input | 2x7 | Tag of the broadcast result |
| bc_val | input | 2x16 | Broadcast result value |
| flush_valid | input | 1 | Remove entries younger than flush_tag |
| flush_tag | input | 7 | Flush boundary tag |
| iss_valid | output | 5 | Issue valid per port |
| iss_op | output | 5x6 | Issued opcode per port |
| iss_tag | output | 5x7 | Issued reorder tag per port |
| iss_s1_val | output | 5x16 | Issued source 1 value per port |
| iss_s2_val | output | 5x16 | Issued source 2 value per port |

## Verification
The assertions check four things on every cycle. No instruction issues in the cycle after a flush or from an empty buffer. Occupancy does not grow after a rejected dispatch and never grows by more than three. Two ports never carry the same tag at once. Other behaviour is shown only by the bench scenarios. These cover oldest-first selection, including tag wrap-around, and broadcast wakeup with the captured value. They also cover capture in the dispatch cycle, arbitrarily long waits, and the exact partition of a flush around its boundary tag.

// File: rtl/rs_sched.sv
module rs_sched #(
  parameter int ENTRIES = 20,
  parameter int DISP    = 3,
  parameter int ISSUE   = 5,
  parameter int NBC     = 2,
  parameter int TAGW    = 7,
  parameter int OPW     = 6,
  parameter int DATAW   = 16,
  localparam int CLSW   = (ISSUE > 1) ? $clog2(ISSUE) : 1,
  localparam int LW     = (DISP > 1) ? $clog2(DISP) : 1,
  localparam int IDXW   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int CNTW   = $clog2(ENTRIES + 1)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [DISP-1:0]                  dsp_valid,
  output logic                             dsp_ready,
  input  logic [DISP-1:0][OPW-1:0]         dsp_op,
  input  logic [DISP-1:0][CLSW-1:0]        dsp_cls,
  input  logic [DISP-1:0][TAGW-1:0]        dsp_tag,
  input  logic [DISP-1:0]                  dsp_s1_rdy,
  input  logic [DISP-1:0][TAGW-1:0]        dsp_s1_tag,
  input  logic [DISP-1:0][DATAW-1:0]       dsp_s1_val,
  input  logic [DISP-1:0]                  dsp_s2_rdy,
  input  logic [DISP-1:0][TAGW-1:0]        dsp_s2_tag,
  input  logic [DISP-1:0][DATAW-1:0]       dsp_s2_val,
  input  logic [NBC-1:0]                   bc_valid,
  input  logic [NBC-1:0][TAGW-1:0]         bc_tag,
  input  logic [NBC-1:0][DATAW-1:0]        bc_val,
  input  logic                             flush_valid,
  input  logic [TAGW-1:0]                  flush_tag,
  output logic [ISSUE-1:0]                 iss_valid,
  output logic [ISSUE-1:0][OPW-1:0]        iss_op,
  output logic [ISSUE-1:0][TAGW-1:0]       iss_tag,
  output logic [ISSUE-1:0][DATAW-1:0]      iss_s1_val,
  output logic [ISSUE-1:0][DATAW-1:0]      iss_s2_val
);

  function automatic logic older(input logic [TAGW-1:0] a, input logic [TAGW-1:0] b);
    logic [TAGW-1:0] d;
    d = a - b;
    return d[TAGW-1];
  endfunction

  logic [ENTRIES-1:0] e_vld;
  logic [OPW-1:0]     e_op  [ENTRIES];
  logic [CLSW-1:0]    e_cls [ENTRIES];
  logic [TAGW-1:0]    e_tag [ENTRIES];
  logic               e_r1  [ENTRIES];
  logic               e_r2  [ENTRIES];
  logic [TAGW-1:0]    e_t1  [ENTRIES];
  logic [TAGW-1:0]    e_t2  [ENTRIES];
  logic [DATAW-1:0]   e_v1  [ENTRIES];
  logic [DATAW-1:0]   e_v2  [ENTRIES];

  logic               d_r1 [DISP];
  logic               d_r2 [DISP];
  logic [DATAW-1:0]   d_v1 [DISP];
  logic [DATAW-1:0]   d_v2 [DISP];

  always_comb begin
    for (int l = 0; l < DISP; l++) begin
      d_r1[l] = dsp_s1_rdy[l];
      d_v1[l] = dsp_s1_val[l];
      d_r2[l] = dsp_s2_rdy[l];
      d_v2[l] = dsp_s2_val[l];
      for (int b = 0; b < NBC; b++) begin
        if (bc_valid[b] && !dsp_s1_rdy[l] && bc_tag[b] == dsp_s1_tag[l]) begin
          d_r1[l] = 1'b1;
          d_v1[l] = bc_val[b];
        end
        if (bc_valid[b] && !dsp_s2_rdy[l] && bc_tag[b] == dsp_s2_tag[l]) begin
          d_r2[l] = 1'b1;
          d_v2[l] = bc_val[b];
        end
      end
    end
  end

  logic [CNTW-1:0] n_req, n_free;
  logic [CNTW-1:0] lane_rank [DISP];
  logic [CNTW-1:0] free_rank [ENTRIES];
  logic [ENTRIES-1:0] wr_en;
  logic [LW-1:0]      wr_lane [ENTRIES];

  always_comb begin
    n_req = '0;
    for (int l = 0; l < DISP; l++) begin
      lane_rank[l] = n_req;
      n_req = n_req + CNTW'(dsp_valid[l]);
    end
    n_free = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      free_rank[e] = n_free;
      n_free = n_free + CNTW'(!e_vld[e]);
    end
  end

  assign dsp_ready = !flush_valid && (n_free >= n_req);

  always_comb begin
    for (int e = 0; e < ENTRIES; e++) begin
      wr_en[e]   = 1'b0;
      wr_lane[e] = '0;
      for (int l = 0; l < DISP; l++) begin
        if (dsp_ready && dsp_valid[l] && !e_vld[e] && lane_rank[l] == free_rank[e]) begin
          wr_en[e]   = 1'b1;
          wr_lane[e] = LW'(l);
        end
      end
    end
  end

  logic [ISSUE-1:0] sel_hit, go;
  logic [IDXW-1:0]  sel_idx [ISSUE];
  logic [TAGW-1:0]  sel_tag [ISSUE];
  logic [OPW-1:0]   sel_op  [ISSUE];
  logic [DATAW-1:0] sel_v1  [ISSUE];
  logic [DATAW-1:0] sel_v2  [ISSUE];
  logic [ENTRIES-1:0] grant;

  always_comb begin
    for (int p = 0; p < ISSUE; p++) begin
      sel_hit[p] = 1'b0;
      sel_idx[p] = '0;
      sel_tag[p] = '0;
      sel_op[p]  = '0;
      sel_v1[p]  = '0;
      sel_v2[p]  = '0;
      for (int e = 0; e < ENTRIES; e++) begin
        if (e_vld[e] && e_r1[e] && e_r2[e] && e_cls[e] == CLSW'(p) &&
            (!sel_hit[p] || older(e_tag[e], sel_tag[p]))) begin
          sel_hit[p] = 1'b1;
          sel_idx[p] = IDXW'(e);
          sel_tag[p] = e_tag[e];
          sel_op[p]  = e_op[e];
          sel_v1[p]  = e_v1[e];
          sel_v2[p]  = e_v2[e];
        end
      end
    end
  end

  assign go = flush_valid ? '0 : sel_hit;

  always_comb begin
    for (int e = 0; e < ENTRIES; e++) begin
      grant[e] = 1'b0;
      for (int p = 0; p < ISSUE; p++)
        if (go[p] && sel_idx[p] == IDXW'(e)) grant[e] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e_vld <= '0;
    end else begin
      for (int e = 0; e < ENTRIES; e++) begin
        for (int b = 0; b < NBC; b++) begin
          if (bc_valid[b] && !e_r1[e] && bc_tag[b] == e_t1[e]) begin
            e_r1[e] <= 1'b1;
            e_v1[e] <= bc_val[b];
          end
          if (bc_valid[b] && !e_r2[e] && bc_tag[b] == e_t2[e]) begin
            e_r2[e] <= 1'b1;
            e_v2[e] <= bc_val[b];
          end
        end
        if (grant[e] || (flush_valid && older(flush_tag, e_tag[e])))
          e_vld[e] <= 1'b0;
        if (wr_en[e]) begin
          e_vld[e] <= 1'b1;
          e_op[e]  <= dsp_op[wr_lane[e]];
          e_cls[e] <= dsp_cls[wr_lane[e]];
          e_tag[e] <= dsp_tag[wr_lane[e]];
          e_r1[e]  <= d_r1[wr_lane[e]];
          e_t1[e]  <= dsp_s1_tag[wr_lane[e]];
          e_v1[e]  <= d_v1[wr_lane[e]];
          e_r2[e]  <= d_r2[wr_lane[e]];
          e_t2[e]  <= dsp_s2_tag[wr_lane[e]];
          e_v2[e]  <= d_v2[wr_lane[e]];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      iss_valid <= '0;
    end else begin
      iss_valid <= go;
      for (int p = 0; p < ISSUE; p++) begin
        if (go[p]) begin
          iss_op[p]     <= sel_op[p];
          iss_tag[p]    <= sel_tag[p];
          iss_s1_val[p] <= sel_v1[p];
          iss_s2_val[p] <= sel_v2[p];
        end
      end
    end
  end

endmodule

// File: rtl/rs_sched_chk.sv
module rs_sched_chk #(
  parameter int ENTRIES = 20,
  parameter int DISP    = 3,
  parameter int ISSUE   = 5,
  parameter int TAGW    = 7
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [DISP-1:0]            dsp_valid,
  input logic                       dsp_ready,
  input logic                       flush_valid,
  input logic [ISSUE-1:0]           iss_valid,
  input logic [ISSUE-1:0][TAGW-1:0] iss_tag,
  input logic [ENTRIES-1:0]         e_vld
);

  // R9
  flush_no_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |=> iss_valid == '0);

  // R8
  reject_no_growth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|dsp_valid && !dsp_ready) |=> $countones(e_vld) <= $past($countones(e_vld)));

  // R10
  dispatch_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(e_vld) <= $past($countones(e_vld)) + DISP);

  // R2
  empty_no_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (e_vld == '0) |=> iss_valid == '0);

  for (genvar p = 0; p < ISSUE; p++) begin : g_pa
    for (genvar q = p + 1; q < ISSUE; q++) begin : g_pb
      // R3
      distinct_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid[p] && iss_valid[q]) |-> iss_tag[p] != iss_tag[q]);
    end
  end

endmodule

bind rs_sched rs_sched_chk #(.ENTRIES(ENTRIES), .DISP(DISP), .ISSUE(ISSUE), .TAGW(TAGW)) u_chk (
  .clk(clk), .rst_n(rst_n), .dsp_valid(dsp_valid), .dsp_ready(dsp_ready),
  .flush_valid(flush_valid), .iss_valid(iss_valid), .iss_tag(iss_tag), .e_vld(e_vld)
);

// File: tb/rs_sched_tb.sv
module rs_sched_tb;
  localparam int DISP = 3, ISSUE = 5, NBC = 2, TAGW = 7, OPW = 6, DATAW = 16, CLSW = 3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n;
  logic [DISP-1:0] dsp_valid, dsp_s1_rdy, dsp_s2_rdy;
  logic dsp_ready;
  logic [DISP-1:0][OPW-1:0] dsp_op;
  logic [DISP-1:0][CLSW-1:0] dsp_cls;
  logic [DISP-1:0][TAGW-1:0] dsp_tag, dsp_s1_tag, dsp_s2_tag;
  logic [DISP-1:0][DATAW-1:0] dsp_s1_val, dsp_s2_val;
  logic [NBC-1:0] bc_valid;
  logic [NBC-1:0][TAGW-1:0] bc_tag;
  logic [NBC-1:0][DATAW-1:0] bc_val;
  logic flush_valid;
  logic [TAGW-1:0] flush_tag;
  logic [ISSUE-1:0] iss_valid;
  logic [ISSUE-1:0][OPW-1:0] iss_op;
  logic [ISSUE-1:0][TAGW-1:0] iss_tag;
  logic [ISSUE-1:0][DATAW-1:0] iss_s1_val, iss_s2_val;

  rs_sched u_dut (.*);

  int total = 0, fails = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic clr();
    dsp_valid = '0; dsp_s1_rdy = '0; dsp_s2_rdy = '0;
    dsp_op = '0; dsp_cls = '0; dsp_tag = '0;
    dsp_s1_tag = '0; dsp_s2_tag = '0; dsp_s1_val = '0; dsp_s2_val = '0;
    bc_valid = '0; bc_tag = '0; bc_val = '0;
    flush_valid = 1'b0; flush_tag = '0;
  endtask

  task automatic put(input int l, input int cls, input int tag, input int op,
                     input bit r1, input int t1, input int v1,
                     input bit r2, input int t2, input int v2);
    dsp_valid[l] = 1'b1;
    dsp_cls[l] = CLSW'(cls); dsp_tag[l] = TAGW'(tag); dsp_op[l] = OPW'(op);
    dsp_s1_rdy[l] = r1; dsp_s1_tag[l] = TAGW'(t1); dsp_s1_val[l] = DATAW'(v1);
    dsp_s2_rdy[l] = r2; dsp_s2_tag[l] = TAGW'(t2); dsp_s2_val[l] = DATAW'(v2);
  endtask

  task automatic bcast(input int b, input int tag, input int val);
    bc_valid[b] = 1'b1; bc_tag[b] = TAGW'(tag); bc_val[b] = DATAW'(val);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  localparam int NV = 6;
  localparam int V_LANE [NV] = '{0, 1, 2, 0, 1, 2};
  localparam int V_CLS  [NV] = '{0, 1, 2, 3, 4, 2};
  localparam int V_TAG  [NV] = '{3, 17, 40, 63, 90, 127};
  localparam int V_OP   [NV] = '{5, 12, 33, 63, 1, 42};
  localparam int V_A    [NV] = '{16'h1111, 16'h0, 16'hFFFF, 16'h1234, 16'hA5A5, 16'h0F0F};
  localparam int V_B    [NV] = '{16'h2222, 16'h8000, 16'h0001, 16'h4321, 16'h5A5A, 16'hF0F0};

  initial begin
    repeat (5000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    bit seen;
    int cnt;
    clr();
    rst_n = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R1
    check("R1 iss_valid", 32'(iss_valid), 0);
    check("R1 dsp_ready", 32'(dsp_ready), 1);

    // R2 vector table
    for (int i = 0; i < NV; i++) begin
      put(V_LANE[i], V_CLS[i], V_TAG[i], V_OP[i], 1, 0, V_A[i], 1, 0, V_B[i]);
      step();
      clr();
      check("R2 not early", 32'(iss_valid), 0);
      step();
      check("R2 R3 port", 32'(iss_valid), 32'(1 << V_CLS[i]));
      check("R2 op", 32'(iss_op[V_CLS[i]]), 32'(V_OP[i]));
      check("R2 tag", 32'(iss_tag[V_CLS[i]]), 32'(V_TAG[i]));
      check("R2 s1", 32'(iss_s1_val[V_CLS[i]]), 32'(V_A[i]));
      check("R2 s2", 32'(iss_s2_val[V_CLS[i]]), 32'(V_B[i]));
      step();
    end

    // R3 R5: five classes wake on one broadcast and issue together
    for (int l = 0; l < 3; l++) put(l, l, 1 + l, 10 + l, 1, 0, l, 0, 100, 0);
    step(); clr();
    put(0, 3, 4, 13, 1, 0, 3, 0, 100, 0);
    put(1, 4, 5, 14, 1, 0, 4, 0, 100, 0);
    step(); clr();
    check("R7 waiting", 32'(iss_valid), 0);
    bcast(0, 100, 16'hBEEF);
    step(); clr();
    check("R5 not same cycle", 32'(iss_valid), 0);
    step();
    check("R3 five ports", 32'(iss_valid), 32'h1F);
    for (int p = 0; p < 5; p++) begin
      check("R5 value", 32'(iss_s2_val[p]), 32'hBEEF);
      check("R3 tag", 32'(iss_tag[p]), 32'(1 + p));
    end
    step();
    check("R3 drained", 32'(iss_valid), 0);

    // R4 oldest first
    put(0, 0, 10, 1, 1, 0, 0, 1, 0, 0);
    put(1, 0, 8, 2, 1, 0, 0, 1, 0, 0);
    put(2, 0, 9, 3, 1, 0, 0, 1, 0, 0);
    step(); clr(); step();
    check("R4 first", 32'(iss_tag[0]), 8);
    check("R3 single per port", 32'(iss_valid), 1);
    step();
    check("R4 second", 32'(iss_tag[0]), 9);
    step();
    check("R4 third", 32'(iss_tag[0]), 10);
    step();
    check("R4 done", 32'(iss_valid), 0);
    // R4 wrap
    put(0, 2, 1, 1, 1, 0, 0, 1, 0, 0);
    put(1, 2, 126, 2, 1, 0, 0, 1, 0, 0);
    step(); clr(); step();
    check("R4 wrap older", 32'(iss_tag[2]), 126);
    step();
    check("R4 wrap younger", 32'(iss_tag[2]), 1);
    step();

    // R6 capture during dispatch cycle
    put(0, 1, 20, 7, 0, 50, 0, 1, 0, 16'h0042);
    bcast(1, 50, 16'h1234);
    step(); clr(); step();
    check("R6 issued", 32'(iss_valid), 2);
    check("R6 value", 32'(iss_s1_val[1]), 32'h1234);
    step();

    // R7 long wait
    put(2, 4, 30, 9, 1, 0, 16'h7, 0, 60, 0);
    step(); clr();
    seen = 0;
    for (int i = 0; i < 30; i++) begin
      step();
      if (iss_valid != 0) seen = 1;
    end
    check("R7 held", 32'(seen), 0);
    bcast(0, 60, 16'hCAFE);
    step(); clr(); step();
    check("R7 issued", 32'(iss_valid), 32'h10);
    check("R7 value", 32'(iss_s2_val[4]), 32'hCAFE);
    step();

    // R8 R10 fill and back-pressure
    for (int c = 0; c < 6; c++) begin
      for (int l = 0; l < 3; l++) put(l, 0, 3 * c + l, 0, 1, 0, 0, 0, 70, 0);
      #0.1;
      check("R10 three lanes accepted", 32'(dsp_ready), 1);
      step(); clr();
    end
    put(0, 0, 18, 0, 1, 0, 0, 0, 70, 0);
    put(1, 0, 19, 0, 1, 0, 0, 0, 70, 0);
    put(2, 1, 40, 0, 1, 0, 0, 1, 0, 0);
    #0.1;
    check("R8 two free three asked", 32'(dsp_ready), 0);
    step(); clr();
    put(0, 0, 18, 0, 1, 0, 0, 0, 70, 0);
    put(1, 0, 19, 0, 1, 0, 0, 0, 70, 0);
    #0.1;
    check("R8 two free two asked", 32'(dsp_ready), 1);
    step(); clr();
    put(0, 1, 41, 0, 1, 0, 0, 1, 0, 0);
    #0.1;
    check("R8 full", 32'(dsp_ready), 0);
    step(); clr();
    check("R8 rejected not issued", 32'(iss_valid), 0);
    bcast(0, 70, 16'h0055);
    step(); clr();
    cnt = 0; seen = 0;
    for (int i = 0; i < 20; i++) begin
      step();
      if (iss_valid[1]) seen = 1;
      if (iss_valid[0] && iss_tag[0] == TAGW'(i)) cnt++;
    end
    check("R10 twenty in order", 32'(cnt), 20);
    check("R8 rejected lanes ignored", 32'(seen), 0);
    step();
    check("R10 empty", 32'(iss_valid), 0);

    // R9 flush partition
    put(0, 0, 20, 0, 1, 0, 0, 0, 80, 0);
    put(1, 1, 21, 0, 1, 0, 0, 0, 80, 0);
    put(2, 2, 22, 0, 1, 0, 0, 0, 80, 0);
    step(); clr();
    flush_valid = 1'b1; flush_tag = 7'd21;
    #0.1;
    check("R8 ready low in flush", 32'(dsp_ready), 0);
    step(); clr();
    bcast(0, 80, 16'h0009);
    step(); clr(); step();
    check("R9 survivors", 32'(iss_valid), 32'h3);
    step();
    // R9 no issue after flush
    put(0, 3, 30, 0, 1, 0, 0, 1, 0, 0);
    step(); clr();
    flush_valid = 1'b1; flush_tag = 7'd40;
    step(); clr();
    check("R9 no issue after flush", 32'(iss_valid), 0);
    step();
    check("R9 older kept", 32'(iss_valid), 32'h8);
    check("R9 older tag", 32'(iss_tag[3]), 30);
    step();

    finish_run();
  end
endmodule